// File: doc/BRIEF.md
# FM Operator Phase Generator

This block produces the phase of each of 24 FM operator slots. One arithmetic path is shared among the slots in time order. A free-running slot counter picks the active slot. While a slot is active, the surrounding logic presents that slot's pitch parameters: frequency number, octave block, key code, detune code and multiplier code. The block turns them into a 20-bit phase increment and stores it for that slot.

Two other slots are handled in the same cycle, each at a fixed offset ahead of the active slot. For one of them, the stored increment is cleared if its phase-reset request is raised. For the other, the phase is stepped by its stored increment, or forced to zero on a reset request. The envelope unit supplies the reset requests as one bit per slot. Pitch modulation from the LFO is not part of this block; it is taken as zero.

The phase of the active slot is shown on `phase_o`, together with the slot number and the channel number. A waveform lookup downstream can consume these directly.

Top module: `fm_phase_gen`

## Requirements
- R1: After reset, `slot_o` is 0, `chan_o` is 0 and every stored phase and increment is 0. `slot_o` then counts up by one each cycle from 0 to 23 and wraps to 0. `chan_o` always equals `slot_o` modulo 6.
- R2: The base frequency is computed in three steps. The frequency number is doubled. It is then shifted left by the block value (0..7). Finally it is shifted right by two, giving a 17-bit result.
- R3: A multiplier code of 0 stands for a factor of one half. Any other code N stands for a factor of N. The increment is the detuned frequency times twice that factor, shifted right by one and kept to 20 bits.
- R4: The detune amount starts from the key code, clamped to at most 28. Its upper three bits give b and its lower two bits give n. Let t be 0, 2 or 3 for detune magnitude codes 1, 2 or 3 (detune bits 1:0). Let s = b + 9 + t. The amount is the ROM entry at index {s bit 0, n}, shifted right by 9 − (s >> 1). The ROM holds 16, 17, 19, 20, 22, 24, 27, 29.
- R5: A detune magnitude code of 0 gives a detune amount of 0. When detune bit 2 is set, the amount is subtracted from the base frequency; when it is clear, the amount is added. The result wraps to 17 bits, so a subtraction below zero wraps around.
- R6: The increment for slot k is computed from the parameter inputs presented in the cycle where `slot_o` equals k. It is stored at the next clock edge.
- R7: In the cycle where `slot_o` is k, bit ((k+20) mod 24) of `phase_rst_i` clears that slot's stored increment.
- R8: In the cycle where `slot_o` is k, slot j = (k+19) mod 24 is updated. If bit j of `phase_rst_i` is set, its phase becomes 0. Otherwise its stored increment is added to its phase, modulo 2^20.
- R9: `phase_o` shows the stored phase of the slot shown on `slot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fnum_i | input | 11 | Frequency number of the active slot |
| block_i | input | 3 | Octave block of the active slot |
| kcode_i | input | 5 | Key code of the active slot |
| dt_i | input | 3 | Detune code of the active slot (bit 2 = sign, bits 1:0 = magnitude) |
| mul_i | input | 4 | Multiplier code of the active slot |
| phase_rst_i | input | 24 | Phase-reset request, one bit per slot |
| slot_o | output | 5 | Active slot number |
| chan_o | output | 3 | Channel of the active slot |
| phase_o | output | 20 | Stored phase of the active slot |

## Verification
Some behaviour is checked by assertions on every cycle:
- The slot and channel counters step and wrap correctly.
- A reset request clears the increment of the slot at offset +20.
- A reset request zeroes the phase of the slot at offset +19.
- Without a request, that phase advances by exactly its stored increment, modulo 2^20.

The arithmetic of the increment can only be shown by the bench's scenarios. This covers block scaling, the half-step multiplier, the clamped key code, the detune lookup and sign, and the 17-bit wrap on subtraction. The bench compares the accumulated phases against a model written from the requirements. It covers boundary cases such as key codes above 28 and a frequency number of zero with negative detune.

// File: rtl/fmpg_pkg.sv
package fmpg_pkg;
    localparam int NUM_SLOTS_DEF = 24;
    localparam int CH_PER_GRP    = 6;
    localparam int PHASE_W_DEF   = 20;
    localparam int FNUM_W_DEF    = 11;
    localparam int BLK_W_DEF     = 3;
    localparam int FREQ_W_DEF    = 17;
    localparam int MUL_W_DEF     = 4;
    localparam int DT_W          = 3;
    localparam int DT_ROM_W      = 8;
    localparam int DT_ROM_DEPTH  = 8;
    localparam int CLR_OFS       = 20;
    localparam int STEP_OFS      = 19;
    localparam int KC_MAX        = 28;
endpackage

// File: rtl/fmpg_slot_seq.sv
module fmpg_slot_seq
    import fmpg_pkg::*;
#(
    parameter int NUM_SLOTS = NUM_SLOTS_DEF,
    parameter int CH_GRP    = CH_PER_GRP,
    parameter int CLR_OFFS  = CLR_OFS,
    parameter int STEP_OFFS = STEP_OFS,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CH_W     = $clog2(CH_GRP)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_q_o,
    output logic [CH_W-1:0]   chan_q_o,
    output logic [SLOT_W-1:0] clr_idx_o,
    output logic [SLOT_W-1:0] step_idx_o
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [CH_W-1:0]   chan;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [SLOT_W:0] clr_sum, step_sum;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.slot == SLOT_W'(NUM_SLOTS - 1)) seq_d.slot = '0;
        else                                      seq_d.slot = seq_q.slot + 1'b1;
        if (seq_q.chan == CH_W'(CH_GRP - 1) || seq_q.slot == SLOT_W'(NUM_SLOTS - 1))
            seq_d.chan = '0;
        else
            seq_d.chan = seq_q.chan + 1'b1;

        clr_sum  = {1'b0, seq_q.slot} + (SLOT_W + 1)'(CLR_OFFS);
        step_sum = {1'b0, seq_q.slot} + (SLOT_W + 1)'(STEP_OFFS);
        if (clr_sum >= (SLOT_W + 1)'(NUM_SLOTS))  clr_sum  = clr_sum  - (SLOT_W + 1)'(NUM_SLOTS);
        if (step_sum >= (SLOT_W + 1)'(NUM_SLOTS)) step_sum = step_sum - (SLOT_W + 1)'(NUM_SLOTS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign slot_q_o   = seq_q.slot;
    assign chan_q_o   = seq_q.chan;
    assign clr_idx_o  = clr_sum[SLOT_W-1:0];
    assign step_idx_o = step_sum[SLOT_W-1:0];

    // R1
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.slot == SLOT_W'(NUM_SLOTS - 1)) |=> (seq_q.slot == '0));
    // R1
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.slot != SLOT_W'(NUM_SLOTS - 1)) |=> (seq_q.slot == $past(seq_q.slot) + 1'b1));
    // R1
    chan_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.slot == '0) |-> (seq_q.chan == '0));
endmodule

// File: rtl/fmpg_detune.sv
module fmpg_detune
    import fmpg_pkg::*;
#(
    parameter int BLK_W = BLK_W_DEF,
    parameter logic [DT_ROM_W-1:0] DT_ROM [DT_ROM_DEPTH] =
        '{8'd16, 8'd17, 8'd19, 8'd20, 8'd22, 8'd24, 8'd27, 8'd29},
    localparam int KC_W = BLK_W + 2,
    localparam int SUM_W = KC_W
) (
    input  logic [KC_W-1:0]     kcode_i,
    input  logic [DT_W-1:0]     dt_i,
    output logic [DT_ROM_W-1:0] amt_o
);
    logic [DT_ROM_W-1:0] rom [DT_ROM_DEPTH];

    for (genvar gi = 0; gi < DT_ROM_DEPTH; gi++) begin : g_rom
        assign rom[gi] = DT_ROM[gi];
    end

    logic [KC_W-1:0]  kc;
    logic [1:0]       term;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] shamt;

    always_comb begin
        kc    = (kcode_i > KC_W'(KC_MAX)) ? KC_W'(KC_MAX) : kcode_i;
        term  = {dt_i[1], dt_i[1] & dt_i[0]};
        sum   = SUM_W'(kc[KC_W-1:2]) + SUM_W'(9) + SUM_W'(term);
        shamt = SUM_W'(9) - (sum >> 1);
        if (dt_i[1:0] == 2'b00) amt_o = '0;
        else                    amt_o = rom[{sum[0], kc[1:0]}] >> shamt;
    end
endmodule

// File: rtl/fmpg_inc.sv
module fmpg_inc
    import fmpg_pkg::*;
#(
    parameter int FNUM_W  = FNUM_W_DEF,
    parameter int BLK_W   = BLK_W_DEF,
    parameter int FREQ_W  = FREQ_W_DEF,
    parameter int MUL_W   = MUL_W_DEF,
    parameter int PHASE_W = PHASE_W_DEF,
    localparam int KC_W   = BLK_W + 2,
    localparam int SHL_W  = FNUM_W + 1 + (2 ** BLK_W - 1),
    localparam int PROD_W = FREQ_W + MUL_W + 1
) (
    input  logic [FNUM_W-1:0]  fnum_i,
    input  logic [BLK_W-1:0]   block_i,
    input  logic [KC_W-1:0]    kcode_i,
    input  logic [DT_W-1:0]    dt_i,
    input  logic [MUL_W-1:0]   mul_i,
    output logic [PHASE_W-1:0] inc_o
);
    logic [DT_ROM_W-1:0] dt_amt;

    fmpg_detune #(.BLK_W(BLK_W)) u_detune (
        .kcode_i (kcode_i),
        .dt_i    (dt_i),
        .amt_o   (dt_amt)
    );

    logic [SHL_W-1:0]  shifted;
    logic [FREQ_W-1:0] base;
    logic [FREQ_W-1:0] adj;
    logic [MUL_W:0]    mulv;
    logic [PROD_W-1:0] prod;

    always_comb begin
        shifted = SHL_W'({fnum_i, 1'b0}) << block_i;
        base    = FREQ_W'(shifted >> 2);
        if (dt_i[2]) adj = base - FREQ_W'(dt_amt);
        else         adj = base + FREQ_W'(dt_amt);
        mulv    = (mul_i == '0) ? (MUL_W + 1)'(1) : {mul_i, 1'b0};
        prod    = PROD_W'(adj) * PROD_W'(mulv);
        inc_o   = prod[PHASE_W:1];
    end
endmodule

// File: rtl/fm_phase_gen.sv
module fm_phase_gen
    import fmpg_pkg::*;
#(
    parameter int NUM_SLOTS = NUM_SLOTS_DEF,
    parameter int PHASE_W   = PHASE_W_DEF,
    parameter int FNUM_W    = FNUM_W_DEF,
    parameter int BLK_W     = BLK_W_DEF,
    parameter int FREQ_W    = FREQ_W_DEF,
    parameter int MUL_W     = MUL_W_DEF,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CH_W     = $clog2(CH_PER_GRP),
    localparam int KC_W     = BLK_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FNUM_W-1:0]    fnum_i,
    input  logic [BLK_W-1:0]     block_i,
    input  logic [KC_W-1:0]      kcode_i,
    input  logic [DT_W-1:0]      dt_i,
    input  logic [MUL_W-1:0]     mul_i,
    input  logic [NUM_SLOTS-1:0] phase_rst_i,
    output logic [SLOT_W-1:0]    slot_o,
    output logic [CH_W-1:0]      chan_o,
    output logic [PHASE_W-1:0]   phase_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][PHASE_W-1:0] phase;
        logic [NUM_SLOTS-1:0][PHASE_W-1:0] inc;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic [SLOT_W-1:0]  slot_q, clr_idx, step_idx;
    logic [CH_W-1:0]    chan_q;
    logic [PHASE_W-1:0] new_inc;

    fmpg_slot_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_q_o   (slot_q),
        .chan_q_o   (chan_q),
        .clr_idx_o  (clr_idx),
        .step_idx_o (step_idx)
    );

    fmpg_inc #(
        .FNUM_W  (FNUM_W),
        .BLK_W   (BLK_W),
        .FREQ_W  (FREQ_W),
        .MUL_W   (MUL_W),
        .PHASE_W (PHASE_W)
    ) u_inc (
        .fnum_i  (fnum_i),
        .block_i (block_i),
        .kcode_i (kcode_i),
        .dt_i    (dt_i),
        .mul_i   (mul_i),
        .inc_o   (new_inc)
    );

    always_comb begin
        st_d = st_q;
        if (phase_rst_i[clr_idx]) st_d.inc[clr_idx] = '0;
        if (phase_rst_i[step_idx]) st_d.phase[step_idx] = '0;
        else st_d.phase[step_idx] = st_q.phase[step_idx] + st_q.inc[step_idx];
        st_d.inc[slot_q] = new_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o  = slot_q;
    assign chan_o  = chan_q;
    assign phase_o = st_q.phase[slot_q];

    // R7
    inc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst_i[clr_idx] |=> (st_q.inc[$past(clr_idx)] == '0));
    // R8
    phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst_i[step_idx] |=> (st_q.phase[$past(step_idx)] == '0));
    // R8
    phase_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_rst_i[step_idx] |=> (st_q.phase[$past(step_idx)] ==
            PHASE_W'($past(st_q.phase[step_idx]) + $past(st_q.inc[step_idx]))));
    // R6
    inc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.inc[$past(slot_q)] == $past(new_inc)));
endmodule

// File: tb/fm_phase_gen_bench.sv
`timescale 1ns/1ps
module fm_phase_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] fnum_i = '0;
    logic [2:0]  block_i = '0;
    logic [4:0]  kcode_i = '0;
    logic [2:0]  dt_i = '0;
    logic [3:0]  mul_i = '0;
    logic [23:0] phase_rst_i = '0;
    logic [4:0]  slot_o;
    logic [2:0]  chan_o;
    logic [19:0] phase_o;

    fm_phase_gen u_fm_phase_gen (
        .clk(clk), .rst_n(rst_n), .fnum_i(fnum_i), .block_i(block_i),
        .kcode_i(kcode_i), .dt_i(dt_i), .mul_i(mul_i), .phase_rst_i(phase_rst_i),
        .slot_o(slot_o), .chan_o(chan_o), .phase_o(phase_o)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    int m_cnt = 0;
    int m_phase [24];
    int m_inc [24];
    string tag = "R1";
    localparam int DT_TAB [8] = '{16, 17, 19, 20, 22, 24, 27, 29};

    function automatic int calc_inc(int fn, int blk, int kc, int dt, int mul);
        int bf, d, t, s, m;
        bf = ((fn * 2) << blk) >> 2;
        d = 0;
        if ((dt & 3) != 0) begin
            if (kc > 28) kc = 28;
            t = ((dt & 3) == 3) ? 3 : (((dt & 3) == 2) ? 2 : 0);
            s = (kc >> 2) + 9 + t;
            d = DT_TAB[((s & 1) << 2) | (kc & 3)] >> (9 - (s >> 1));
        end
        bf = ((dt & 4) != 0) ? bf - d : bf + d;
        bf = bf & 32'h1FFFF;
        m = (mul == 0) ? 1 : 2 * mul;
        return ((bf * m) >> 1) & 32'hFFFFF;
    endfunction

    task automatic check(string t, int act, int exp_v);
        n_vec++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", t, act, exp_v);
        end
    endtask

    task automatic model_step();
        int c, s;
        c = (m_cnt + 20) % 24;
        s = (m_cnt + 19) % 24;
        if (phase_rst_i[c]) m_inc[c] = 0;
        if (phase_rst_i[s]) m_phase[s] = 0;
        else m_phase[s] = (m_phase[s] + m_inc[s]) & 32'hFFFFF;
        m_inc[m_cnt] = calc_inc(fnum_i, block_i, kcode_i, dt_i, mul_i);
        m_cnt = (m_cnt + 1) % 24;
    endtask

    task automatic drive(int mode);
        fnum_i  = 11'($urandom);
        block_i = 3'($urandom);
        kcode_i = 5'($urandom);
        dt_i    = 3'($urandom);
        mul_i   = 4'($urandom);
        phase_rst_i = '0;
        case (mode)
            2: begin dt_i = 3'd0; mul_i = 4'd1; end                    // R2
            3: begin dt_i = 3'd0; if ($urandom % 3 == 0) mul_i = 4'd0; end // R3
            4: begin dt_i = 3'(1 + $urandom % 3);
                     if ($urandom % 2 == 0) kcode_i = 5'(28 + $urandom % 4); end // R4
            5: begin dt_i = 3'(4 + $urandom % 4); fnum_i = 11'($urandom % 8);
                     block_i = 3'd0; end                                // R5
            6: begin dt_i = 3'd7; fnum_i = 11'd0; block_i = 3'd0;
                     kcode_i = 5'd31; mul_i = 4'd15; end                // R5 corner
            7: phase_rst_i[(m_cnt + 20) % 24] = ($urandom % 3 == 0);    // R7
            8: for (int b = 0; b < 24; b++) phase_rst_i[b] = ($urandom % 8 == 0); // R8
            default: ;
        endcase
    endtask

    task automatic run(int mode, int cycles, string t);
        tag = t;
        for (int i = 0; i < cycles; i++) begin
            drive(mode);
            @(posedge clk);
            model_step();
            @(negedge clk);
            check("R1 slot", slot_o, m_cnt);
            check("R1 channel", chan_o, m_cnt % 6);
            check({tag, " R9 phase"}, phase_o, m_phase[m_cnt]);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 24; i++) begin m_phase[i] = 0; m_inc[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset slot", slot_o, 0);
        check("R1 reset channel", chan_o, 0);
        check("R1 reset phase", phase_o, 0);
        rst_n = 1'b1;
        run(2, 240, "R2");
        run(3, 240, "R3");
        run(4, 240, "R4");
        run(5, 240, "R5");
        run(6, 120, "R5");
        run(7, 240, "R7");
        run(8, 240, "R8");
        run(1, 240, "R6");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule